// File: doc/BRIEF.md
# Saturating Counting Semaphore Cell

This block is one memory-mapped 16-bit counting semaphore shared by several hardware threads. A read hands back the present count and then lowers it by one, stopping at zero. A write raises the count by one, holding at the all-ones value, and the data it carries plays no part. Each request carries a thread ID and a view bit that picks how a read of an empty semaphore behaves.

In the try view, a read of an empty semaphore completes at once and returns zero. In the synchronized view, the same read gives no response and the thread is marked in a blocked bitmap. A write that lifts the count off zero while threads are blocked clears the bitmap and pulses a wake output. The cell then replays the parked reads itself, one per cycle and lowest thread ID first, holding off new requests until the replay is done. Replayed reads that find the count at zero again go back to blocked.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the blocked bitmap is all zero, `rsp_valid_o` and `wake_o` are low, and `req_ready_o` is high.
- R2: An accepted read that finds the count nonzero returns that count on `rsp_data_o`, with `rsp_valid_o` high and the request's thread on `rsp_tid_o`, one cycle later. The stored count then drops by exactly one. This holds in either view.
- R3: An accepted write (`req_we_i`=1) raises the count by one, whatever `req_wdata_i` holds. It is answered one cycle later by `rsp_valid_o` high with `rsp_data_o` = 0.
- R4: A write while the count is 0xFFFF leaves it at 0xFFFF.
- R5: A synchronized-view read (`req_try_i`=0) that finds the count at zero produces no response. It sets bit `req_tid_i` of `blocked_o` one cycle later and leaves the count at zero.
- R6: A try-view read (`req_try_i`=1) that finds the count at zero responds one cycle later with data 0. It leaves the count at zero and blocks no thread.
- R7: A write that finds the count at zero while `blocked_o` is nonzero clears `blocked_o` and raises `wake_o` for one cycle, both one cycle later. A write that finds no blocked thread does not raise `wake_o`.
- R8: After a wake, every woken thread's read is replayed as a synchronized-view read. Replays go one per cycle in ascending thread ID, and `req_ready_o` stays low until the last one is taken. A replay that gets the count responds with that thread's ID, and one that finds zero blocks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Cell accepts a request this cycle (low during replay) |
| req_we_i | input | 1 | 1 = write (increment), 0 = read (decrement) |
| req_try_i | input | 1 | 1 = try view, 0 = synchronized view |
| req_tid_i | input | TID_W | Issuing thread |
| req_wdata_i | input | CNT_W | Write data, ignored |
| rsp_valid_o | output | 1 | Response present |
| rsp_tid_o | output | TID_W | Thread the response belongs to |
| rsp_data_o | output | CNT_W | Read result, 0 for writes |
| blocked_o | output | NUM_THR | One bit per thread parked on the cell |
| wake_o | output | 1 | One-cycle pulse when blocked threads are released |

## Verification
The bench sweeps the count up through several depths and drains it with mixed views. A design that decremented before returning would be off by one on every read. One that underflowed would give 0xFFFF after the count was exhausted. The bench pushes the count through 65535 writes and beyond, so a counter that wrapped would read back small values. The wake sequence with three blocked threads checks the order of the replays and the re-block of the losers. A wrong priority shows up as the wrong `rsp_tid_o`. A design that lost a parked read would leave a thread missing from `blocked_o`.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_RD_SYNC = 2'd1,
    OP_RD_TRY  = 2'd2,
    OP_WR      = 2'd3
  } sem_op_e;
endpackage

// File: rtl/sem_counter.sv
module sem_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (inc_i && cnt_q != TOP)    cnt_q <= cnt_q + ONE;
    else if (dec_i && cnt_q != '0)     cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  p_sat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q == TOP) |=> (cnt_q == TOP));
  p_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q == '0) |=> (cnt_q == '0));
  p_dec_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  p_inc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/sem_waitlist.sv
module sem_waitlist #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               block_i,
  input  logic [TID_W-1:0]   block_tid_i,
  input  logic               release_i,
  input  logic               take_i,
  output logic [NUM_THR-1:0] blocked_o,
  output logic               busy_o,
  output logic [TID_W-1:0]   grant_tid_o,
  output logic               wake_o
);
  logic [NUM_THR-1:0] blocked_q, pend_q, grant_oh;
  logic               wake_q;

  // lowest pending thread wins
  always_comb begin
    grant_tid_o = '0;
    grant_oh    = '0;
    for (int i = NUM_THR - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant_tid_o = TID_W'(i);
        grant_oh    = NUM_THR'(1) << i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blocked_q <= '0;
      pend_q    <= '0;
      wake_q    <= 1'b0;
    end else begin
      wake_q <= release_i;
      if (release_i) begin
        pend_q    <= blocked_q;
        blocked_q <= '0;
      end else begin
        if (take_i)  pend_q <= pend_q & ~grant_oh;
        if (block_i) blocked_q[block_tid_i] <= 1'b1;
      end
    end
  end

  assign blocked_o = blocked_q;
  assign busy_o    = |pend_q;
  assign wake_o    = wake_q;

  p_one_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_oh));
  p_block_mark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_i && !release_i) |=> blocked_q[$past(block_tid_i)]);
  p_release_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> (blocked_q == '0 && wake_q));
  p_replay_shrinks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !release_i) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int CNT_W   = 16,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_we_i,
  input  logic               req_try_i,
  input  logic [TID_W-1:0]   req_tid_i,
  input  logic [CNT_W-1:0]   req_wdata_i,
  output logic               rsp_valid_o,
  output logic [TID_W-1:0]   rsp_tid_o,
  output logic [CNT_W-1:0]   rsp_data_o,
  output logic [NUM_THR-1:0] blocked_o,
  output logic               wake_o
);
  sem_op_e          op;
  logic [TID_W-1:0] op_tid, grant_tid;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero, busy, is_rd, do_block, do_release;
  logic             rsp_valid_q;
  logic [TID_W-1:0] rsp_tid_q;
  logic [CNT_W-1:0] rsp_data_q;
  logic             unused_wdata;

  assign unused_wdata = ^req_wdata_i;  // value of a write is not used
  assign req_ready_o  = !busy;

  // replay of woken reads takes the port ahead of new requests
  always_comb begin
    op     = OP_IDLE;
    op_tid = req_tid_i;
    if (busy) begin
      op     = OP_RD_SYNC;
      op_tid = grant_tid;
    end else if (req_valid_i) begin
      if (req_we_i)       op = OP_WR;
      else if (req_try_i) op = OP_RD_TRY;
      else                op = OP_RD_SYNC;
    end
  end

  assign is_rd      = (op == OP_RD_SYNC) || (op == OP_RD_TRY);
  assign do_block   = (op == OP_RD_SYNC) && cnt_zero;
  assign do_release = (op == OP_WR) && cnt_zero && (|blocked_o);

  sem_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (op == OP_WR),
    .dec_i  (is_rd),
    .cnt_o  (cnt),
    .zero_o (cnt_zero)
  );

  sem_waitlist #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_wait (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .block_i     (do_block),
    .block_tid_i (op_tid),
    .release_i   (do_release),
    .take_i      (busy),
    .blocked_o   (blocked_o),
    .busy_o      (busy),
    .grant_tid_o (grant_tid),
    .wake_o      (wake_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_tid_q   <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= (op == OP_WR) || (is_rd && !do_block);
      rsp_tid_q   <= op_tid;
      rsp_data_q  <= (is_rd && !cnt_zero) ? cnt : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_tid_o   = rsp_tid_q;
  assign rsp_data_o  = rsp_data_q;

  p_try_answers_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RD_TRY) |=> rsp_valid_o);
  p_sync_zero_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RD_SYNC && cnt_zero) |=> !rsp_valid_o);
  p_wake_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (blocked_o == '0 && !req_ready_o));
  p_wake_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
endmodule

// File: tb/sim_sem_cell.sv
module sim_sem_cell;
  localparam int NT = 4;
  localparam int CW = 16;
  localparam int TW = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0, req_try = 1'b0;
  logic [TW-1:0] req_tid = '0;
  logic [CW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, wake;
  logic [TW-1:0] rsp_tid;
  logic [CW-1:0] rsp_data;
  logic [NT-1:0] blocked;

  int vec = 0, miss = 0;

  always #10 clk = ~clk;

  sem_cell #(.NUM_THR(NT), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_try_i(req_try), .req_tid_i(req_tid),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_tid_o(rsp_tid), .rsp_data_o(rsp_data),
    .blocked_o(blocked), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, returns at the following negedge with outputs settled
  task automatic op(input bit we, input bit tr, input int tid, input logic [CW-1:0] wd);
    req_valid = 1'b1; req_we = we; req_try = tr; req_tid = TW'(tid); req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(20 * 190000);
    miss++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
    chk(blocked == 0, "R1 blocked", blocked, 0);
    chk(!wake, "R1 wake", wake, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 try reads of an empty cell, every thread
    for (int t = 0; t < NT; t++) begin
      op(0, 1, t, '0);
      chk(rsp_valid && rsp_data == 0 && rsp_tid == TW'(t), "R6 try-zero", {rsp_valid, rsp_data}, 0);
      chk(blocked == 0, "R6 no block", blocked, 0);
    end

    // R2/R3 depth sweep with mixed views and arbitrary write data
    for (int k = 1; k <= 6; k++) begin
      for (int w = 0; w < k; w++) begin
        op(1, w[0], w % NT, CW'(16'hA5A5 ^ (w * 16'h1111)));
        chk(rsp_valid && rsp_data == 0, "R3 write ack", rsp_data, 0);
        chk(!wake, "R7 no wake without waiters", wake, 0);
      end
      for (int r = k; r >= 1; r--) begin
        op(0, r[0], r % NT, '0);
        chk(rsp_valid && rsp_data == CW'(r) && rsp_tid == TW'(r % NT), "R2 read value", rsp_data, r);
      end
      op(0, 1, 0, '0);
      chk(rsp_valid && rsp_data == 0, "R2 drained to zero", rsp_data, 0);
    end

    // R5 synchronized reads at zero park threads 1..3
    for (int t = 1; t < NT; t++) begin
      op(0, 0, t, '0);
      chk(!rsp_valid, "R5 no response", rsp_valid, 0);
      chk(blocked == NT'((1 << (t + 1)) - 2), "R5 blocked map", blocked, (1 << (t + 1)) - 2);
    end
    op(0, 1, 0, '0);
    chk(rsp_valid && rsp_data == 0, "R5 count still zero", rsp_data, 0);

    // R7/R8 wake and ordered replay
    op(1, 0, 0, 16'h1234);
    chk(wake && blocked == 0, "R7 wake clears", {wake, blocked}, 5'h10);
    chk(!req_ready, "R8 ready low in replay", req_ready, 0);
    idle();
    chk(rsp_valid && rsp_tid == 1 && rsp_data == 1, "R8 lowest first", {rsp_tid, rsp_data}, {2'd1, 16'd1});
    chk(!wake, "R7 single pulse", wake, 0);
    idle();
    chk(!rsp_valid && blocked == 4'b0100, "R8 re-block t2", blocked, 4);
    idle();
    chk(blocked == 4'b1100 && req_ready, "R8 re-block t3", {req_ready, blocked}, 5'h1c);

    op(1, 1, 0, '0);
    chk(wake && blocked == 0, "R7 second wake", {wake, blocked}, 5'h10);
    idle();
    chk(rsp_valid && rsp_tid == 2 && rsp_data == 1, "R8 t2 served", {rsp_tid, rsp_data}, {2'd2, 16'd1});
    idle();
    chk(blocked == 4'b1000 && req_ready, "R8 t3 re-block", blocked, 8);
    op(1, 0, 1, '0);
    idle();
    chk(rsp_valid && rsp_tid == 3 && rsp_data == 1, "R8 t3 served", {rsp_tid, rsp_data}, {2'd3, 16'd1});
    chk(blocked == 0, "R8 all served", blocked, 0);

    // R4 saturation
    for (int i = 0; i < 65535 + 3; i++) op(1, 0, i % NT, CW'(i));
    op(0, 1, 2, '0);
    chk(rsp_valid && rsp_data == 16'hFFFF, "R4 saturated", rsp_data, 16'hFFFF);
    op(0, 0, 3, '0);
    chk(rsp_valid && rsp_data == 16'hFFFE, "R4 decrement from top", rsp_data, 16'hFFFE);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule